// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single channel of an interval timer. It holds a 16-bit down-counter that advances once per `clk` edge and drives a single output, `tout`. A `gate` input either enables counting or triggers it, depending on the mode. Six behaviours can be selected: a terminal-count flag, a retriggerable one-shot, a rate generator, a square-wave generator, a load-triggered strobe and a gate-triggered strobe. The count runs in plain binary or in four-digit BCD.

A bus-side controller sits outside this block and handles address decoding, byte ordering and read latching. That controller pulses `cfg_wr` with a three-bit mode code and a BCD flag. It delivers a count by presenting the assembled value on `ld_val` with the `ld_hi` strobe. The `ld_lo` strobe marks that the first byte of a two-byte write has arrived. The live counter value is exposed for the controller to latch.

Top module: `tmr_channel`

## Requirements
- R1: Mode 0 (codes 000): `cfg_wr` forces `tout` low. The `ld_hi` strobe leaves `tout` unchanged. On the next clock `live_count` takes the value n, and `tout` rises on the n+1-th clock after the strobe clock. It then stays high until another count is loaded.
- R2: Mode 0: while `gate` is low, the counter holds. An `ld_lo` strobe freezes the count where it is, and a later `ld_hi` starts a fresh count of the new value.
- R3: Mode 1 (001): the clock that samples a rising `gate` drives `tout` low and starts the count. `tout` stays low for exactly n clocks. A value loaded during the pulse is used only from the next rising `gate`.
- R4: Mode 2 (codes 010 or 110): once counting, `tout` falls for exactly one clock in every n clocks. The first fall comes n clocks after the strobe clock. While `gate` is low, `tout` is forced high. The clock that sees `gate` rise reloads n, so the next fall comes n clocks later.
- R5: Mode 3 (codes 011 or 111): `tout` is high for ceil(n/2) clocks and low for floor(n/2) clocks, period after period.
- R6: Mode 3: a low `gate` forces `tout` high and stops the count. A rising `gate` reloads n, and `tout` then falls ceil(n/2)+1 clocks after `gate` was raised.
- R7: Mode 4 (100): `tout` stays high except for one low clock, which comes n+1 clocks after the strobe clock. `ld_lo` leaves the running count alone, and a new `ld_hi` restarts it.
- R8: Mode 5 (101): each rising `gate` loads the stored value. `tout` pulses low for one clock, n+1 clocks after `gate` was raised. A second rise before the pulse restarts the count.
- R9: `cfg_bcd`=1 selects BCD counting and 0 selects binary, so a loaded 16'h0012 gives a period of 12 in BCD and 18 in binary.
- R10: In BCD, each nibble borrows decimally: 16'h0100 steps to 16'h0099, and 16'h1000 steps to 16'h0999.
- R11: A loaded value of zero acts as the largest count. The next value after it is 16'hFFFF in binary and 16'h9999 in BCD, and a BCD mode-2 period from zero is 10000 clocks.
- R12: After reset `tout` is high and `live_count` is zero. Until a count has been loaded, `tout` stays at the idle level: low in mode 0, high in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_bcd | input | 1 | 1 = BCD counting, 0 = binary |
| ld_lo | input | 1 | First byte of a count write arrived |
| ld_hi | input | 1 | Count write complete; `ld_val` valid |
| ld_val | input | 16 | Count value to store |
| gate | input | 1 | Count enable / trigger |
| tout | output | 1 | Channel output |
| live_count | output | 16 | Current counter value |

## Verification
A wrong counter value or borrow leaves the output waveform looking normal, but its timing is shifted. In the rate and square modes, the first pulse lands one or more clocks away from the expected n, or a half period comes out one clock off for odd n. In the strobe modes, a stuck-low or doubled pulse shows on the clock right after the strobe. A wrong gate-edge state appears within a single clock of the gate change, as a missing restart or an output that is not forced high. BCD borrow errors become visible two clocks after the load, at `live_count`.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [2:0] {
      M_TC       = 3'd0,
      M_ONESHOT  = 3'd1,
      M_RATE     = 3'd2,
      M_SQUARE   = 3'd3,
      M_SWSTROBE = 3'd4,
      M_HWSTROBE = 3'd5
   } tmr_mode_e;

   // Codes x10 and x11 alias rate and square; the rest map directly.
   function automatic tmr_mode_e decode_mode(input logic [2:0] code);
      if (code[1])
         return code[0] ? M_SQUARE : M_RATE;
      return tmr_mode_e'({code[2], 1'b0, code[0]});
   endfunction

endpackage

// File: rtl/tmr_dec.sv
module tmr_dec #(
   parameter int CW = 16
) (
   input  logic [CW-1:0] val,
   input  logic          bcd,
   output logic [CW-1:0] res
);
   localparam int ND = CW / 4;

   logic [ND:0]   brw;
   logic [CW-1:0] bres;

   assign brw[0] = 1'b1;

   for (genvar i = 0; i < ND; i++) begin : g_dig
      logic [3:0] d;
      assign d = val[4*i +: 4];
      assign bres[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
      assign brw[i+1]       = brw[i] && (d == 4'd0);
   end

   assign res = bcd ? bres : (val - CW'(1));

endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
   parameter int CW = 16
) (
   input  logic [CW-1:0] val,
   input  logic          bcd,
   output logic [CW-1:0] half
);
   localparam int ND = CW / 4;

   logic [CW-1:0] bhalf;
   logic          is_zero;

   assign is_zero = (val == '0);

   for (genvar i = 0; i < ND; i++) begin : g_dig
      logic       up;
      logic [3:0] d;
      assign d = val[4*i +: 4];
      if (i < ND - 1) begin : g_mid
         assign up = val[4*i+4];
      end else begin : g_top
         assign up = 1'b0;
      end
      assign bhalf[4*i +: 4] = {1'b0, d[3:1]} + (up ? 4'd5 : 4'd0);
   end

   always_comb begin
      if (bcd)
         half = is_zero ? {4'h5, {(CW-4){1'b0}}} : bhalf;
      else
         half = is_zero ? {1'b1, {(CW-1){1'b0}}} : {1'b0, val[CW-1:1]};
   end

endmodule

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic gate,
   output logic rise
);
   logic gate_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate;
   end

   assign rise = gate & ~gate_q;

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [2:0]    cfg_mode,
   input  logic          cfg_bcd,
   input  logic          ld_lo,
   input  logic          ld_hi,
   input  logic [CW-1:0] ld_val,
   input  logic          gate,
   output logic          tout,
   output logic [CW-1:0] live_count
);
   localparam int ND = CW / 4;

   if (CW % 4 != 0 || ND < 2) begin : g_bad_width
      $error("tmr_channel: CW must be a multiple of 4 and at least 8");
   end

   tmr_mode_e     mode_q;
   logic          bcd_q, have_cr_q, pend_q, run_q, out_q, done_q;
   logic [CW-1:0] cr_q, cnt_q, n_run_q;
   logic [CW-1:0] nxt, half_w;
   logic          rise, nxt_zero, at_one;

   tmr_dec #(.CW(CW)) u_dec (.val(cnt_q), .bcd(bcd_q), .res(nxt));
   tmr_half #(.CW(CW)) u_half (.val(n_run_q), .bcd(bcd_q), .half(half_w));
   tmr_gate_edge u_edge (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(rise));

   assign nxt_zero = (nxt == '0);
   assign at_one   = (cnt_q == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= M_TC;
         bcd_q     <= 1'b0;
         have_cr_q <= 1'b0;
         pend_q    <= 1'b0;
         run_q     <= 1'b0;
         out_q     <= 1'b1;
         done_q    <= 1'b0;
         cr_q      <= '0;
         cnt_q     <= '0;
         n_run_q   <= '0;
      end else if (cfg_wr) begin
         mode_q    <= decode_mode(cfg_mode);
         bcd_q     <= cfg_bcd;
         have_cr_q <= 1'b0;
         pend_q    <= 1'b0;
         run_q     <= 1'b0;
         done_q    <= 1'b0;
         out_q     <= (decode_mode(cfg_mode) == M_TC) ? 1'b0 : 1'b1;
      end else begin
         // counting step, per mode
         unique case (mode_q)
            M_TC: begin
               if (pend_q) begin
                  pend_q <= 1'b0;
                  cnt_q  <= cr_q;
                  run_q  <= 1'b1;
                  out_q  <= 1'b0;
               end else if (run_q && gate) begin
                  cnt_q <= nxt;
                  if (nxt_zero) out_q <= 1'b1;
               end
            end
            M_ONESHOT: begin
               if (rise && have_cr_q) begin
                  cnt_q <= cr_q;
                  run_q <= 1'b1;
                  out_q <= 1'b0;
               end else if (run_q) begin
                  cnt_q <= nxt;
                  if (nxt_zero) begin
                     out_q <= 1'b1;
                     run_q <= 1'b0;
                  end
               end
            end
            M_RATE: begin
               if (pend_q) begin
                  pend_q <= 1'b0;
                  cnt_q  <= cr_q;
                  run_q  <= 1'b1;
                  out_q  <= 1'b1;
               end else if (run_q) begin
                  if (!gate) begin
                     out_q <= 1'b1;
                  end else if (rise || at_one) begin
                     cnt_q <= cr_q;
                     out_q <= 1'b1;
                  end else begin
                     cnt_q <= nxt;
                     out_q <= (nxt != CW'(1));
                  end
               end
            end
            M_SQUARE: begin
               if (pend_q) begin
                  pend_q  <= 1'b0;
                  cnt_q   <= cr_q;
                  n_run_q <= cr_q;
                  run_q   <= 1'b1;
                  out_q   <= 1'b1;
               end else if (run_q) begin
                  if (!gate) begin
                     out_q <= 1'b1;
                  end else if (rise || at_one) begin
                     cnt_q   <= cr_q;
                     n_run_q <= cr_q;
                     out_q   <= 1'b1;
                  end else begin
                     cnt_q <= nxt;
                     out_q <= (nxt > half_w);
                  end
               end
            end
            M_SWSTROBE: begin
               out_q <= 1'b1;
               if (pend_q) begin
                  pend_q <= 1'b0;
                  cnt_q  <= cr_q;
                  run_q  <= 1'b1;
                  done_q <= 1'b0;
               end else if (run_q && gate) begin
                  cnt_q <= nxt;
                  if (nxt_zero && !done_q) begin
                     out_q  <= 1'b0;
                     done_q <= 1'b1;
                  end
               end
            end
            M_HWSTROBE: begin
               out_q <= 1'b1;
               if (rise && have_cr_q) begin
                  cnt_q <= cr_q;
                  run_q <= 1'b1;
               end else if (run_q) begin
                  cnt_q <= nxt;
                  if (nxt_zero) begin
                     out_q <= 1'b0;
                     run_q <= 1'b0;
                  end
               end
            end
            default: out_q <= 1'b1;
         endcase

         // count writes from the bus side
         if (ld_hi) begin
            cr_q      <= ld_val;
            have_cr_q <= 1'b1;
            if (mode_q == M_TC || mode_q == M_SWSTROBE ||
                ((mode_q == M_RATE || mode_q == M_SQUARE) && !run_q))
               pend_q <= 1'b1;
         end
         if (ld_lo && mode_q == M_TC)
            run_q <= 1'b0;
      end
   end

   assign tout       = out_q;
   assign live_count = cnt_q;

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gate,
   input logic       tout,
   input logic       cfg_wr,
   input logic       pend,
   input logic [2:0] mode
);

   // R1: terminal-count flag stays high until a new count is transferred
   p_tc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 && tout && !cfg_wr && !pend) |=> tout);

   // R4: low gate forces the rate output high
   p_rate_gate_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2 && !gate && !cfg_wr) |=> tout);

   // R4: rate pulse is exactly one clock wide
   p_rate_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2 && !tout && !cfg_wr) |=> tout);

   // R6: low gate forces the square output high
   p_sq_gate_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && !gate && !cfg_wr) |=> tout);

   // R7 and R8: strobes last one clock
   p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == 3'd4 || mode == 3'd5) && !tout && !cfg_wr) |=> tout);

endmodule

bind tmr_channel tmr_channel_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .gate   (gate),
   .tout   (tout),
   .cfg_wr (cfg_wr),
   .pend   (pend_q),
   .mode   (mode_q)
);

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 16;
   localparam int CAP        = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_mode = 3'd0;
   logic          cfg_bcd = 1'b0;
   logic          ld_lo = 1'b0;
   logic          ld_hi = 1'b0;
   logic [CW-1:0] ld_val = '0;
   logic          gate = 1'b1;
   logic          tout;
   logic [CW-1:0] live_count;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;
   int  seed_dummy;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_channel #(.CW(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
      .cfg_bcd(cfg_bcd), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_val(ld_val),
      .gate(gate), .tout(tout), .live_count(live_count)
   );

   function automatic int exp_high(int n); return (n + 1) / 2; endfunction
   function automatic int exp_low(int n);  return n / 2;       endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic configure(logic [2:0] code, logic b);
      cfg_mode = code; cfg_bcd = b; cfg_wr = 1'b1;
      step();
      cfg_wr = 1'b0;
   endtask

   task automatic load(logic [CW-1:0] v);
      ld_val = v; ld_hi = 1'b1;
      step();
      ld_hi = 1'b0;
   endtask

   task automatic strobe_lo();
      ld_lo = 1'b1;
      step();
      ld_lo = 1'b0;
   endtask

   task automatic wait_level(logic lvl, output int n);
      n = 0;
      while (tout !== lvl && n < CAP) begin
         step();
         n++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int c;
      seed_dummy = $urandom(32'h5EED_0042);
      repeat (3) step();
      chk("R12 reset tout", int'(tout), 1);
      chk("R12 reset count", int'(live_count), 0);
      rst_n = 1'b1;
      step();

      // R12 idle levels
      configure(3'b000, 1'b0);
      chk("R12 mode0 idle", int'(tout), 0);
      configure(3'b010, 1'b0);
      repeat (3) step();
      chk("R12 mode2 idle", int'(tout), 1);
      gate = 1'b0;
      configure(3'b001, 1'b0);
      step(); gate = 1'b1; step(); step();
      chk("R12 mode1 no count", int'(tout), 1);
      gate = 1'b1;

      // R1 random counts in mode 0
      for (int k = 0; k < 4; k++) begin
         int n = $urandom_range(2, 40);
         configure(3'b000, 1'b0);
         load(CW'(n));
         chk("R1 out unchanged by load", int'(tout), 0);
         step();
         chk("R1 count transferred", int'(live_count), n);
         wait_level(1'b1, c);
         chk("R1 terminal timing", c + 1, n + 1);
         repeat (3) step();
         chk("R1 holds high", int'(tout), 1);
      end

      // R2 gate pause
      begin
         int n = $urandom_range(4, 30);
         int g = $urandom_range(1, 9);
         configure(3'b000, 1'b0);
         load(CW'(n));
         step(); step();
         gate = 1'b0;
         repeat (g) step();
         gate = 1'b1;
         wait_level(1'b1, c);
         chk("R2 gate pause", c, n - 1);
      end

      // R2 low-byte halt, high-byte restart
      begin
         int n = $urandom_range(6, 30);
         int m = $urandom_range(2, 30);
         configure(3'b000, 1'b0);
         load(CW'(n));
         step(); step();
         strobe_lo();
         chk("R2 halted value", int'(live_count), n - 2);
         repeat (4) step();
         chk("R2 stays halted", int'(live_count), n - 2);
         chk("R2 out still low", int'(tout), 0);
         load(CW'(m));
         wait_level(1'b1, c);
         chk("R2 restart timing", c, m + 1);
      end

      // R3 one-shot
      for (int k = 0; k < 3; k++) begin
         int n = $urandom_range(3, 30);
         int m = $urandom_range(1, 30);
         gate = 1'b0;
         configure(3'b001, 1'b0);
         load(CW'(n));
         step();
         gate = 1'b1;
         step();
         chk("R3 pulse starts", int'(tout), 0);
         wait_level(1'b1, c);
         chk("R3 pulse width", c, n);
         gate = 1'b0; step(); gate = 1'b1; step();
         load(CW'(m));
         wait_level(1'b1, c);
         chk("R3 midpulse load ignored", c, n - 1);
         gate = 1'b0; step(); gate = 1'b1; step();
         chk("R3 retrigger low", int'(tout), 0);
         wait_level(1'b1, c);
         chk("R3 new count used", c, m);
      end

      // R4 rate generator
      for (int k = 0; k < 3; k++) begin
         int n = $urandom_range(2, 40);
         gate = 1'b1;
         configure(3'b010, 1'b0);
         load(CW'(n));
         wait_level(1'b0, c);
         chk("R4 first pulse", c, n);
         step();
         chk("R4 pulse width", int'(tout), 1);
         wait_level(1'b0, c);
         chk("R4 period", c + 1, n);
         step();
         gate = 1'b0;
         step();
         chk("R4 gate low high", int'(tout), 1);
         step(); step();
         chk("R4 gate low hold", int'(tout), 1);
         gate = 1'b1;
         wait_level(1'b0, c);
         chk("R4 gate restart", c, n);
      end

      // R5 and R6 square wave, odd and even
      for (int k = 0; k < 4; k++) begin
         int n = $urandom_range(4, 40);
         if (k == 0) n = 7;
         if (k == 1) n = 10;
         gate = 1'b1;
         configure(3'b011, 1'b0);
         load(CW'(n));
         wait_level(1'b0, c);
         chk("R5 first high", c, exp_high(n) + 1);
         wait_level(1'b1, c);
         chk("R5 low half", c, exp_low(n));
         wait_level(1'b0, c);
         chk("R5 high half", c, exp_high(n));
         gate = 1'b0;
         step();
         chk("R6 gate low high", int'(tout), 1);
         step(); step();
         gate = 1'b1;
         wait_level(1'b0, c);
         chk("R6 gate restart", c, exp_high(n) + 1);
      end

      // R7 software strobe
      begin
         int n = $urandom_range(5, 30);
         gate = 1'b1;
         configure(3'b100, 1'b0);
         load(CW'(n));
         wait_level(1'b0, c);
         chk("R7 strobe timing", c, n + 1);
         step();
         chk("R7 strobe width", int'(tout), 1);
         repeat (n + 4) step();
         chk("R7 single strobe", int'(tout), 1);
         load(CW'(n));
         step(); step();
         strobe_lo();
         wait_level(1'b0, c);
         chk("R7 low byte no effect", c + 3, n + 1);
         step();
         load(CW'(n));
         repeat (3) step();
         load(CW'(n));
         wait_level(1'b0, c);
         chk("R7 high byte restart", c, n + 1);
      end

      // R8 gate-triggered strobe
      begin
         int n = $urandom_range(4, 30);
         gate = 1'b0;
         configure(3'b101, 1'b0);
         load(CW'(n));
         step();
         gate = 1'b1;
         wait_level(1'b0, c);
         chk("R8 strobe timing", c, n + 1);
         step();
         chk("R8 strobe width", int'(tout), 1);
         gate = 1'b0; step();
         gate = 1'b1; step(); step();
         gate = 1'b0; step();
         gate = 1'b1;
         wait_level(1'b0, c);
         chk("R8 retrigger restart", c, n + 1);
      end

      // R9 BCD vs binary, alias codes
      gate = 1'b1;
      configure(3'b110, 1'b1);
      load(16'h0012);
      wait_level(1'b0, c);
      chk("R9 bcd first pulse", c, 12);
      step();
      wait_level(1'b0, c);
      chk("R9 bcd period", c + 1, 12);
      configure(3'b010, 1'b0);
      load(16'h0012);
      wait_level(1'b0, c);
      chk("R9 binary first pulse", c, 18);
      configure(3'b111, 1'b1);
      load(16'h0011);
      wait_level(1'b0, c);
      wait_level(1'b1, c);
      chk("R9 bcd square low", c, 5);
      wait_level(1'b0, c);
      chk("R9 bcd square high", c, 6);

      // R10 BCD borrow
      configure(3'b000, 1'b1);
      load(16'h0100);
      step();
      chk("R10 bcd loaded", int'(live_count), 16'h0100);
      step();
      chk("R10 bcd borrow 0100", int'(live_count), 16'h0099);
      configure(3'b000, 1'b1);
      load(16'h1000);
      step(); step();
      chk("R10 bcd borrow 1000", int'(live_count), 16'h0999);

      // R11 zero as maximum
      configure(3'b000, 1'b0);
      load(16'h0000);
      step(); step();
      chk("R11 binary wrap", int'(live_count), 16'hFFFF);
      chk("R11 out still low", int'(tout), 0);
      configure(3'b000, 1'b1);
      load(16'h0000);
      step(); step();
      chk("R11 bcd wrap", int'(live_count), 16'h9999);
      configure(3'b010, 1'b1);
      load(16'h0000);
      wait_level(1'b0, c);
      chk("R11 bcd max period", c, 10000);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule